// File: doc/BRIEF.md
# Serial Port Command Strobe Decoder

This block sits behind the write-only command register of a serial port. Each write is one word. Every bit that is written as 1 asks for one action. A set bit either changes a stored level or fires a strobe that lasts one clock. A bit written as 0 does nothing, so the register has no value to read back. The block stores the transmitter and receiver enable levels and the two modem outputs: request-to-send (RTS) and data-terminal-ready (DTR). It sends reset pulses to the transmit and receive sections, a clear pulse to the status flags, and start or stop pulses to the neighbouring break and timeout logic.

Where a write carries an enable bit and its matching disable bit together, the disable bit takes effect. The RTS commands depend on the port's operating mode. In the hardware-handshake mode (mode value 2), the enable command raises RTS. In every other mode, the enable command lowers it. All outputs are registered.

Top module: `scmd_decoder`

## Requirements
- R1: During and after synchronous reset, both enable levels are 0, RTS is 1, DTR is 1 and every strobe is 0.
- R2: Bit 6 (transmit enable) sets `tx_en_o` in the cycle after the write, unless bit 7 (transmit disable) or bit 3 (transmit reset) is also set in that word. Bit 7 clears `tx_en_o`.
- R3: Bit 4 (receive enable) sets `rx_en_o` in the cycle after the write, unless bit 5 (receive disable) or bit 2 (receive reset) is also set in that word. Bit 5 clears `rx_en_o`.
- R4: A bit written as 0, any bit outside the defined positions, and any cycle with `wr_en_i` low leave the stored levels unchanged and raise no strobe.
- R5: When `mode_i` equals 2, bit 18 drives RTS to 1 and bit 19 drives RTS to 0. If both bits are set, RTS goes to 0.
- R6: When `mode_i` is any value other than 2, bit 18 drives RTS to 0 and bit 19 drives RTS to 1. If both bits are set, RTS goes to 1.
- R7: Bit 16 drives DTR to 0 and bit 17 drives DTR to 1. If both bits are set, DTR goes to 1.
- R8: Bit 3 pulses `tx_rst_o` and clears `tx_en_o`. Bit 2 pulses `rx_rst_o` and clears `rx_en_o`.
- R9: Bit 8 pulses `sta_clr_o`, which clears the parity, framing, overrun and break-received flags.
- R10: Bit 9 pulses `brk_start_o` and bit 10 pulses `brk_stop_o`.
- R11: Bit 11 pulses `to_arm_o` (wait for a character, then start the timeout). Bit 15 pulses `to_restart_o` (restart the timeout now).
- R12: Every strobe is high only in the cycle that follows the accepting write edge. It drops in the next cycle unless a new write sets the same bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Command write strobe |
| wr_data_i | input | DATA_W (32) | Command word, one action per set bit |
| mode_i | input | MODE_W (4) | Operating mode; value 2 selects handshake RTS polarity |
| tx_en_o | output | 1 | Transmitter enable level |
| rx_en_o | output | 1 | Receiver enable level |
| rts_o | output | 1 | Request-to-send pin level |
| dtr_o | output | 1 | Data-terminal-ready pin level |
| tx_rst_o | output | 1 | Transmitter reset strobe |
| rx_rst_o | output | 1 | Receiver reset strobe |
| sta_clr_o | output | 1 | Status flag clear strobe |
| brk_start_o | output | 1 | Break start strobe |
| brk_stop_o | output | 1 | Break stop strobe |
| to_arm_o | output | 1 | Timeout arm-after-next-character strobe |
| to_restart_o | output | 1 | Timeout immediate restart strobe |

## Verification
Each output passes through exactly one register. A write presented before edge N therefore shows up in the levels and strobes during the cycle that follows edge N. The strobes must be low again one edge later. The bench drives the write on a falling edge and reads every result at the next falling edge. After that idle edge it samples a second time to confirm that each strobe has dropped and each level has held. A separate back-to-back test confirms that a strobe stays high for two cycles when the same bit is written twice in a row.

// File: rtl/scmd_pkg.sv
package scmd_pkg;

    // Command bit positions; software encodes these, so they are fixed.
    localparam int B_RST_RX    = 2;
    localparam int B_RST_TX    = 3;
    localparam int B_RX_ON     = 4;
    localparam int B_RX_OFF    = 5;
    localparam int B_TX_ON     = 6;
    localparam int B_TX_OFF    = 7;
    localparam int B_STA_CLR   = 8;
    localparam int B_BRK_START = 9;
    localparam int B_BRK_STOP  = 10;
    localparam int B_TO_ARM    = 11;
    localparam int B_TO_NOW    = 15;
    localparam int B_DTR_LOW   = 16;
    localparam int B_DTR_HIGH  = 17;
    localparam int B_RTS_ON    = 18;
    localparam int B_RTS_OFF   = 19;
    localparam int TOP_BIT     = B_RTS_OFF;

    // Index of each stored level
    typedef enum int {
        LV_TX  = 0,
        LV_RX  = 1,
        LV_RTS = 2,
        LV_DTR = 3
    } level_e;
    localparam int LV_N = 4;

    typedef struct packed {
        logic rst_rx;
        logic rst_tx;
        logic rx_on;
        logic rx_off;
        logic tx_on;
        logic tx_off;
        logic sta_clr;
        logic brk_start;
        logic brk_stop;
        logic to_arm;
        logic to_now;
        logic dtr_low;
        logic dtr_high;
        logic rts_on;
        logic rts_off;
    } cmd_t;

    typedef struct packed {
        logic tx_rst;
        logic rx_rst;
        logic sta_clr;
        logic brk_start;
        logic brk_stop;
        logic to_arm;
        logic to_restart;
    } pulse_t;
    localparam int PULSE_W = $bits(pulse_t);

    function automatic cmd_t decode_cmd(input logic [TOP_BIT:0] w, input logic wr);
        cmd_t c;
        c.rst_rx    = wr & w[B_RST_RX];
        c.rst_tx    = wr & w[B_RST_TX];
        c.rx_on     = wr & w[B_RX_ON];
        c.rx_off    = wr & w[B_RX_OFF];
        c.tx_on     = wr & w[B_TX_ON];
        c.tx_off    = wr & w[B_TX_OFF];
        c.sta_clr   = wr & w[B_STA_CLR];
        c.brk_start = wr & w[B_BRK_START];
        c.brk_stop  = wr & w[B_BRK_STOP];
        c.to_arm    = wr & w[B_TO_ARM];
        c.to_now    = wr & w[B_TO_NOW];
        c.dtr_low   = wr & w[B_DTR_LOW];
        c.dtr_high  = wr & w[B_DTR_HIGH];
        c.rts_on    = wr & w[B_RTS_ON];
        c.rts_off   = wr & w[B_RTS_OFF];
        return c;
    endfunction

    // Reset value of each stored level: enables low, modem pins high
    function automatic logic level_init(input int idx);
        return (idx == LV_RTS) || (idx == LV_DTR);
    endfunction

endpackage

// File: rtl/scmd_level_latch.sv
module scmd_level_latch #(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    always_ff @(posedge clk) begin
        if (rst)        q_o <= INIT;
        else if (clr_i) q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
    end

    // The low-going request has priority (disable-over-enable, R2 R3 R5 R6 R7)
    assert_clr_wins_R2: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !q_o);
    assert_set_takes_R3: assert property (@(posedge clk) disable iff (rst)
        (set_i && !clr_i) |=> q_o);
    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/scmd_strobe_reg.sv
module scmd_strobe_reg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst) q_o <= '0;
        else     q_o <= d_i;
    end

    assert_follow_R12: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q_o == $past(d_i)));

endmodule

// File: rtl/scmd_decoder.sv
module scmd_decoder
    import scmd_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int MODE_W  = 4,
    parameter int HS_MODE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              tx_en_o,
    output logic              rx_en_o,
    output logic              rts_o,
    output logic              dtr_o,
    output logic              tx_rst_o,
    output logic              rx_rst_o,
    output logic              sta_clr_o,
    output logic              brk_start_o,
    output logic              brk_stop_o,
    output logic              to_arm_o,
    output logic              to_restart_o
);

    localparam logic [MODE_W-1:0] HS_VAL = MODE_W'(HS_MODE);

    cmd_t   cmd;
    pulse_t pulse_d;
    pulse_t pulse_q;
    logic   hs_mode;

    logic [LV_N-1:0] lv_set;
    logic [LV_N-1:0] lv_clr;
    logic [LV_N-1:0] lv_q;

    assign cmd     = decode_cmd(wr_data_i[TOP_BIT:0], wr_en_i);
    assign hs_mode = (mode_i == HS_VAL);

    // Per-level set/clear requests; clear has priority inside the latch
    always_comb begin
        lv_set[LV_TX]  = cmd.tx_on;
        lv_clr[LV_TX]  = cmd.tx_off | cmd.rst_tx;
        lv_set[LV_RX]  = cmd.rx_on;
        lv_clr[LV_RX]  = cmd.rx_off | cmd.rst_rx;
        lv_set[LV_DTR] = cmd.dtr_high;
        lv_clr[LV_DTR] = cmd.dtr_low & ~cmd.dtr_high;
        if (hs_mode) begin
            lv_set[LV_RTS] = cmd.rts_on;
            lv_clr[LV_RTS] = cmd.rts_off;
        end else begin
            lv_set[LV_RTS] = cmd.rts_off;
            lv_clr[LV_RTS] = cmd.rts_on & ~cmd.rts_off;
        end
    end

    for (genvar i = 0; i < LV_N; i++) begin : g_level
        scmd_level_latch #(
            .INIT (level_init(i))
        ) u_lv (
            .clk   (clk),
            .rst   (rst),
            .set_i (lv_set[i]),
            .clr_i (lv_clr[i]),
            .q_o   (lv_q[i])
        );
    end

    always_comb begin
        pulse_d.tx_rst     = cmd.rst_tx;
        pulse_d.rx_rst     = cmd.rst_rx;
        pulse_d.sta_clr    = cmd.sta_clr;
        pulse_d.brk_start  = cmd.brk_start;
        pulse_d.brk_stop   = cmd.brk_stop;
        pulse_d.to_arm     = cmd.to_arm;
        pulse_d.to_restart = cmd.to_now;
    end

    scmd_strobe_reg #(
        .W (PULSE_W)
    ) u_strobe (
        .clk (clk),
        .rst (rst),
        .d_i (pulse_d),
        .q_o (pulse_q)
    );

    assign tx_en_o      = lv_q[LV_TX];
    assign rx_en_o      = lv_q[LV_RX];
    assign rts_o        = lv_q[LV_RTS];
    assign dtr_o        = lv_q[LV_DTR];
    assign tx_rst_o     = pulse_q.tx_rst;
    assign rx_rst_o     = pulse_q.rx_rst;
    assign sta_clr_o    = pulse_q.sta_clr;
    assign brk_start_o  = pulse_q.brk_start;
    assign brk_stop_o   = pulse_q.brk_stop;
    assign to_arm_o     = pulse_q.to_arm;
    assign to_restart_o = pulse_q.to_restart;

    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> !(tx_rst_o | rx_rst_o | sta_clr_o | brk_start_o |
                       brk_stop_o | to_arm_o | to_restart_o));
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> ($stable(tx_en_o) && $stable(rx_en_o) &&
                      $stable(rts_o) && $stable(dtr_o)));
    assert_rts_hs_off_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && mode_i == HS_VAL && wr_data_i[B_RTS_OFF]) |=> !rts_o);
    assert_rts_norm_off_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && mode_i != HS_VAL && wr_data_i[B_RTS_OFF]) |=> rts_o);
    assert_dtr_high_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_data_i[B_DTR_HIGH]) |=> dtr_o);
    assert_tx_reset_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_data_i[B_RST_TX]) |=> (tx_rst_o && !tx_en_o));
    assert_rx_reset_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_data_i[B_RST_RX]) |=> (rx_rst_o && !rx_en_o));

endmodule

// File: tb/sim_scmd_decoder.sv
module sim_scmd_decoder;

    localparam int NV = 26;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [3:0]  mode = '0;
    logic tx_en, rx_en, rts, dtr, tx_rst, rx_rst, sta_clr;
    logic brk_start, brk_stop, to_arm, to_restart;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    scmd_decoder u0 (
        .clk          (clk),
        .rst          (rst),
        .wr_en_i      (wr_en),
        .wr_data_i    (wr_data),
        .mode_i       (mode),
        .tx_en_o      (tx_en),
        .rx_en_o      (rx_en),
        .rts_o        (rts),
        .dtr_o        (dtr),
        .tx_rst_o     (tx_rst),
        .rx_rst_o     (rx_rst),
        .sta_clr_o    (sta_clr),
        .brk_start_o  (brk_start),
        .brk_stop_o   (brk_stop),
        .to_arm_o     (to_arm),
        .to_restart_o (to_restart)
    );

    // Packed view: {tx_en, rx_en, rts, dtr, tx_rst, rx_rst, sta_clr,
    //               brk_start, brk_stop, to_arm, to_restart}
    function automatic logic [10:0] outs();
        return {tx_en, rx_en, rts, dtr, tx_rst, rx_rst, sta_clr,
                brk_start, brk_stop, to_arm, to_restart};
    endfunction

    localparam logic [31:0] VD [NV] = '{
        32'h0000_0040, 32'h0000_0010, 32'h0000_0000, 32'h0000_0080,
        32'h0000_00C0, 32'h0000_0030, 32'h0000_0050, 32'h0000_0048,
        32'h0000_0004, 32'h0001_0000, 32'h0003_0000, 32'h0004_0000,
        32'h0008_0000, 32'h0008_0000, 32'h0004_0000, 32'h000C_0000,
        32'h000C_0000, 32'h0004_0000, 32'h0000_0100, 32'h0000_0200,
        32'h0000_0400, 32'h0000_0800, 32'h0000_8000, 32'hFFFF_FFFF,
        32'h0000_0050, 32'hFFFF_0000};
    localparam logic [3:0] VM [NV] = '{
        4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0,
        4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd2, 4'd2, 4'd2,
        4'd0, 4'd5, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0,
        4'd0, 4'd2};
    localparam logic [10:0] VE [NV] = '{
        11'b1011_0000000, // R2 tx enable
        11'b1111_0000000, // R3 rx enable
        11'b1111_0000000, // R4 zero word
        11'b0111_0000000, // R2 tx disable
        11'b0111_0000000, // R2 enable+disable
        11'b0011_0000000, // R3 enable+disable
        11'b1111_0000000, // R2 R3 both on
        11'b0111_1000000, // R8 tx reset beats enable
        11'b0011_0100000, // R8 rx reset
        11'b0010_0000000, // R7 dtr low
        11'b0011_0000000, // R7 both -> high
        11'b0001_0000000, // R6 rts on, mode 0 -> low
        11'b0011_0000000, // R6 rts off, mode 0 -> high
        11'b0001_0000000, // R5 rts off, mode 2 -> low
        11'b0011_0000000, // R5 rts on, mode 2 -> high
        11'b0001_0000000, // R5 both, mode 2 -> low
        11'b0011_0000000, // R6 both, mode 0 -> high
        11'b0001_0000000, // R6 rts on, mode 5 -> low
        11'b0001_0010000, // R9 status clear
        11'b0001_0001000, // R10 break start
        11'b0001_0000100, // R10 break stop
        11'b0001_0000010, // R11 timeout arm
        11'b0001_0000001, // R11 timeout restart
        11'b0011_1111111, // R8 R12 all bits
        11'b1111_0000000, // R2 R3 re-enable
        11'b1101_0000000  // R4 R5 upper half only
    };

    task automatic check(input string req, input logic [10:0] exp);
        n_tests++;
        if (outs() !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, outs(), exp);
        end
    endtask

    initial begin
        logic [10:0] held;
        // R1: state during reset
        repeat (3) @(negedge clk);
        check("R1 in reset", 11'b0011_0000000);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", 11'b0011_0000000);

        // R4: wr_en low with every bit set changes nothing
        wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        check("R4 wr_en low", 11'b0011_0000000);

        // Vector table: write, sample next cycle, then idle and re-sample
        for (int i = 0; i < NV; i++) begin
            wr_en   = 1'b1;
            wr_data = VD[i];
            mode    = VM[i];
            @(negedge clk);
            wr_en   = 1'b0;
            wr_data = '0;
            check($sformatf("vector %0d", i), VE[i]);
            @(negedge clk);
            check($sformatf("R12 drop after vector %0d", i),
                  {VE[i][10:7], 7'b0});
        end

        // R12: back-to-back writes keep a strobe high for two cycles
        wr_en   = 1'b1;
        wr_data = 32'h0000_0100;
        @(negedge clk);
        held = outs();
        check("R12 back-to-back first", {held[10:7], 7'b0010000});
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
        check("R12 back-to-back second", {held[10:7], 7'b0010000});
        @(negedge clk);
        check("R12 back-to-back drop", {held[10:7], 7'b0});

        // R1: reset mid-run restores reset levels
        wr_en   = 1'b1;
        wr_data = 32'h0005_0050;
        @(negedge clk);
        wr_en = 1'b0;
        rst   = 1'b1;
        @(negedge clk);
        check("R1 re-reset", 11'b0011_0000000);
        rst = 1'b0;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hung expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule